// File: doc/BRIEF.md
# Three-Wire Half-Duplex Serial Master

This block runs register transactions over a three-wire link: an active-high chip enable, a serial clock and a single data line that both ends drive in turn. A host raises `start` for one cycle with a direction, a six-bit register address and a byte count. The block then raises chip enable and sends a command byte. After that it either sends the data bytes the host supplies, or it releases the data line and collects the bytes the slave returns. A burst moves up to sixteen consecutive bytes under one chip-enable window. The host sees `busy` for the whole transaction, a `done` pulse when chip enable drops, one `rdata`/`rvalid` pulse for each byte read, and one `wready` pulse each time a write byte is taken from `wdata`.

The data line is split into `sio_out`, `sio_oe` and `sio_in` so that a pad cell outside the block can join them. A half-bit divider sets the serial clock rate from the system clock. `HALF_DIV` system cycles make one half of a serial clock period. The default of 13 keeps a 50 MHz system clock just under a 2 MHz serial clock.

Top module: `tw_serial_master`

## Requirements
- R1: After reset, `ce`, `sclk`, `sio_oe`, `sio_out`, `busy`, `done`, `rvalid` and `wready` are all 0.
- R2: The first byte of every transaction is the command {1, addr[5:0], rw}, with rw = 1 for read. Write at address 0 is therefore 0x80, and read at address 63 is 0xFF. It is sent least significant bit first and is valid at each rising edge of `sclk`.
- R3: `sio_out` changes only while `sclk` is low. It holds its value through every cycle in which `sclk` is high.
- R4: A write moves len+1 data bytes after the command, each least significant bit first. There is exactly one `wready` pulse per byte. `wdata` is taken in the cycle `wready` is high, and the first pulse comes at the end of the command byte.
- R5: In a read, `sio_oe` falls at the falling `sclk` edge that ends the last command bit. It stays 0 for the rest of the transaction. The master samples `sio_in` at the end of each low half. It returns len+1 bytes on `rdata` with one `rvalid` pulse each, assembled least significant bit first.
- R6: `ce` stays high from before the first rising `sclk` edge until after the last one. `sclk` is 0 whenever `ce` is 0. Within a transaction, successive rising `sclk` edges are exactly 2*HALF_DIV system cycles apart.
- R7: `busy` is 1 from the cycle after `start` is accepted until the end-of-transaction gap is over. `done` pulses exactly once per transaction, for one cycle, in the first cycle with `ce` low.
- R8: Between two transactions, `ce` stays low for at least 2*HALF_DIV system cycles.
- R9: A `start` pulse while `busy` is 1 is ignored. The running transaction keeps its command and length, and no further transaction follows it.
- R10: A transaction with count len gives exactly 8*(len+2) rising `sclk` edges.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | One-cycle request; taken only when not busy |
| rw | input | 1 | 1 = read, 0 = write |
| addr | input | 6 | Register address |
| len | input | 4 | Data byte count minus one (0 = single byte) |
| wdata | input | 8 | Write byte; taken in the cycle wready is high |
| wready | output | 1 | Pulse: wdata is taken in this cycle |
| rdata | output | 8 | Last byte read |
| rvalid | output | 1 | Pulse: rdata holds a new byte |
| busy | output | 1 | Transaction in progress, gap included |
| done | output | 1 | Pulse when chip enable drops |
| ce | output | 1 | Active-high chip enable |
| sclk | output | 1 | Serial clock, idles low |
| sio_out | output | 1 | Data line value driven by the master |
| sio_oe | output | 1 | 1 = master drives the data line |
| sio_in | input | 1 | Data line value seen at the pad |

## Verification
The bench contains a model slave. It checks each command and write byte as it arrives and drives read bytes on falling edges from its own memory. A design that released the line one bit late would fail the drive-enable check at the first data rising edge. One that sampled on the wrong half would return bytes shifted by one bit. The bench covers single-byte and 16-byte bursts, the address extremes 0 and 63, and back-to-back transactions. A wrong bit order, command format or burst length shows up as a scoreboard mismatch, a wrong `wready` count or a wrong rising-edge count. A `start` injected in the middle of a read catches a design that restarts or queues a request while busy. A missing chip-enable gap is caught by the low-time measurement.

// File: rtl/tw_pkg.sv
// Shared constants, state type and command builder for the three-wire master.
package tw_pkg;

    localparam int CMD_W  = 8;
    localparam int ADDR_W = CMD_W - 2;
    localparam int BIT_W  = $clog2(CMD_W);

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LEAD,
        ST_LOW,
        ST_HIGH,
        ST_TAIL,
        ST_GAP
    } link_state_t;

    // Command byte: top bit set, address in the middle, direction in bit 0.
    function automatic logic [CMD_W-1:0] make_cmd(input logic rd, input logic [ADDR_W-1:0] a);
        return {1'b1, a, rd};
    endfunction

endpackage

// File: rtl/tw_halfbit_timer.sv
// Half-bit timer: pulses tick once every HALF_DIV cycles while run is high.
// Assumes HALF_DIV >= 1; the count restarts from zero each time run rises.
module tw_halfbit_timer #(
    parameter int HALF_DIV = 13
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic tick
);
    localparam int CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(HALF_DIV - 1);

    logic [CW-1:0] cnt;

    // Count system cycles within a half bit; hold at zero when idle.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) cnt <= '0;
        else if (cnt == LAST) cnt <= '0;
        else cnt <= cnt + 1'b1;
    end

    assign tick = run && (cnt == LAST);

endmodule

// File: rtl/tw_link_fsm.sv
// Link sequencer: shifts the command and data bytes LSB first, turns the data
// line around for reads and sequences the chip-enable window and the gap.
// Assumes tick arrives once per half bit while busy is high.
module tw_link_fsm
    import tw_pkg::*;
#(
    parameter int LEN_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              start,
    input  logic              rw,
    input  logic [ADDR_W-1:0] addr,
    input  logic [LEN_W-1:0]  len,
    input  logic [CMD_W-1:0]  wdata,
    output logic              wready,
    output logic [CMD_W-1:0]  rdata,
    output logic              rvalid,
    output logic              busy,
    output logic              done,
    output logic              ce,
    output logic              sclk,
    output logic              sio_out,
    output logic              sio_oe,
    input  logic              sio_in
);
    localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(CMD_W - 1);

    link_state_t      state;
    logic [CMD_W-1:0] shreg;
    logic [BIT_W-1:0] bit_idx;
    logic [LEN_W-1:0] remain;
    logic             rd_q;
    logic             data_ph;
    logic             gap_half;
    logic             byte_end;
    logic             rd_data;

    assign byte_end = tick && (state == ST_HIGH) && (bit_idx == LAST_BIT);
    assign rd_data  = rd_q && data_ph;

    // Ask for a write byte at the end of the command and each non-final data byte.
    assign wready = byte_end && !rd_q && (!data_ph || (remain != '0));

    // Line and status decode from the state register.
    assign busy    = (state != ST_IDLE);
    assign ce      = (state == ST_LEAD) || (state == ST_LOW) ||
                     (state == ST_HIGH) || (state == ST_TAIL);
    assign sclk    = (state == ST_HIGH);
    assign sio_out = sio_oe & shreg[0];

    // Main sequencer: one step per half bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            shreg    <= '0;
            bit_idx  <= '0;
            remain   <= '0;
            rd_q     <= 1'b0;
            data_ph  <= 1'b0;
            gap_half <= 1'b0;
            sio_oe   <= 1'b0;
            rdata    <= '0;
            rvalid   <= 1'b0;
            done     <= 1'b0;
        end else begin
            rvalid <= 1'b0;
            done   <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (start) begin
                        state    <= ST_LEAD;
                        shreg    <= make_cmd(rw, addr);
                        rd_q     <= rw;
                        remain   <= len;
                        bit_idx  <= '0;
                        data_ph  <= 1'b0;
                        gap_half <= 1'b0;
                        sio_oe   <= 1'b1;
                    end
                end
                ST_LEAD: if (tick) state <= ST_LOW;
                ST_LOW: begin
                    if (tick) begin
                        if (rd_data) shreg <= {sio_in, shreg[CMD_W-1:1]};
                        state <= ST_HIGH;
                    end
                end
                ST_HIGH: begin
                    if (tick) begin
                        if (bit_idx != LAST_BIT) begin
                            bit_idx <= bit_idx + 1'b1;
                            if (!rd_data) shreg <= {1'b0, shreg[CMD_W-1:1]};
                            state <= ST_LOW;
                        end else begin
                            bit_idx <= '0;
                            if (!data_ph) begin
                                data_ph <= 1'b1;
                                state   <= ST_LOW;
                                if (rd_q) sio_oe <= 1'b0;
                                else      shreg  <= wdata;
                            end else begin
                                if (rd_q) begin
                                    rdata  <= shreg;
                                    rvalid <= 1'b1;
                                end
                                if (remain == '0) begin
                                    state <= ST_TAIL;
                                end else begin
                                    remain <= remain - 1'b1;
                                    state  <= ST_LOW;
                                    if (!rd_q) shreg <= wdata;
                                end
                            end
                        end
                    end
                end
                ST_TAIL: begin
                    if (tick) begin
                        state  <= ST_GAP;
                        sio_oe <= 1'b0;
                        shreg  <= '0;
                        done   <= 1'b1;
                    end
                end
                ST_GAP: begin
                    if (tick) begin
                        if (gap_half) state <= ST_IDLE;
                        gap_half <= 1'b1;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/tw_serial_master.sv
// Three-wire half-duplex serial master top: joins the half-bit timer and the
// link sequencer. Assumes an external pad merges sio_out/sio_oe/sio_in.
module tw_serial_master #(
    parameter int HALF_DIV = 13,
    parameter int LEN_W    = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             rw,
    input  logic [5:0]       addr,
    input  logic [LEN_W-1:0] len,
    input  logic [7:0]       wdata,
    output logic             wready,
    output logic [7:0]       rdata,
    output logic             rvalid,
    output logic             busy,
    output logic             done,
    output logic             ce,
    output logic             sclk,
    output logic             sio_out,
    output logic             sio_oe,
    input  logic             sio_in
);
    logic tick;

    tw_halfbit_timer #(.HALF_DIV(HALF_DIV)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (busy),
        .tick  (tick)
    );

    tw_link_fsm #(.LEN_W(LEN_W)) u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (tick),
        .start   (start),
        .rw      (rw),
        .addr    (addr),
        .len     (len),
        .wdata   (wdata),
        .wready  (wready),
        .rdata   (rdata),
        .rvalid  (rvalid),
        .busy    (busy),
        .done    (done),
        .ce      (ce),
        .sclk    (sclk),
        .sio_out (sio_out),
        .sio_oe  (sio_oe),
        .sio_in  (sio_in)
    );

endmodule

// File: rtl/tw_link_checker.sv
// Protocol checker for the three-wire master, bound to the top module.
module tw_link_checker #(
    parameter int HALF_DIV = 13
) (
    input logic clk,
    input logic rst_n,
    input logic ce,
    input logic sclk,
    input logic sio_out,
    input logic sio_oe,
    input logic busy,
    input logic done,
    input logic rvalid,
    input logic wready
);
    localparam int LIM = 2 * HALF_DIV;
    localparam int GW  = $clog2(LIM + 1) + 1;

    logic [GW-1:0] gap_cnt;

    // Count cycles with chip enable low, saturating at the required gap.
    always_ff @(posedge clk) begin
        if (!rst_n) gap_cnt <= GW'(LIM);
        else if (ce) gap_cnt <= '0;
        else if (gap_cnt < GW'(LIM)) gap_cnt <= gap_cnt + 1'b1;
    end

    assert_sclk_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !ce |-> !sclk);

    assert_data_stable_R3: assert property (@(posedge clk) disable iff (!rst_n)
        sclk |-> $stable(sio_out));

    assert_done_at_ce_drop_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ce) |-> (done && busy));

    assert_done_ce_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !ce);

    assert_line_released_R5: assert property (@(posedge clk) disable iff (!rst_n)
        rvalid |-> !sio_oe);

    assert_wready_driving_R4: assert property (@(posedge clk) disable iff (!rst_n)
        wready |-> (busy && sio_oe && ce));

    assert_ce_gap_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ce) |-> (gap_cnt >= GW'(LIM)));

endmodule

bind tw_serial_master tw_link_checker #(.HALF_DIV(HALF_DIV)) u_link_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .ce      (ce),
    .sclk    (sclk),
    .sio_out (sio_out),
    .sio_oe  (sio_oe),
    .busy    (busy),
    .done    (done),
    .rvalid  (rvalid),
    .wready  (wready)
);

// File: tb/tb_tw_serial_master.sv
// Scoreboard bench: the driver queues expected bytes, a model slave and an
// rdata monitor pop and compare them as the link produces them.
module tb_tw_serial_master;
    localparam int HD = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic       rw = 1'b0;
    logic [5:0] addr = '0;
    logic [3:0] len = '0;
    logic [7:0] wdata = '0;
    logic       sio_in = 1'b0;
    logic       wready, rvalid, busy, done, ce, sclk, sio_out, sio_oe;
    logic [7:0] rdata;

    tw_serial_master #(.HALF_DIV(HD), .LEN_W(4)) dut (
        .clk(clk), .rst_n(rst_n), .start(start), .rw(rw), .addr(addr),
        .len(len), .wdata(wdata), .wready(wready), .rdata(rdata),
        .rvalid(rvalid), .busy(busy), .done(done), .ce(ce), .sclk(sclk),
        .sio_out(sio_out), .sio_oe(sio_oe), .sio_in(sio_in)
    );

    always #10 clk = ~clk;

    int tests = 0;
    int fails = 0;
    int cyc = 0;
    bit finished = 0;

    logic [7:0] cmd_q[$];
    logic [7:0] wr_q[$];
    logic [7:0] rd_q[$];
    logic [7:0] ref_mem[64];
    logic [7:0] slv_mem[64];
    logic [7:0] tx_buf[16];
    int exp_len = 0;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc >= 150000 && !finished) begin
            fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    // Model slave: captures on rising sclk, drives read bits on falling sclk.
    bit         s_psclk = 0, s_pce = 0, s_pout = 0, s_cmd_ok = 0, s_rd = 0;
    int         s_bits = 0, s_idx = 0, s_rbit = 0, s_rbyte = 0, s_rises = 0;
    int         s_last_rise = -1, s_low = 1000;
    logic [7:0] s_sh = '0;
    logic [5:0] s_addr = '0;

    always @(negedge clk) begin
        if (rst_n) begin
            if (ce && !s_pce) begin
                chk(s_low >= 2 * HD, "R8 ce low gap", s_low, 2 * HD);
                s_bits = 0; s_cmd_ok = 0; s_rd = 0; s_idx = 0;
                s_rbit = 0; s_rbyte = 0; s_rises = 0; s_last_rise = -1;
            end
            if (!ce) s_low++; else s_low = 0;
            if (!ce && sclk) chk(0, "R6 sclk high with ce low", 1, 0);
            if (sclk && s_psclk && (sio_out != s_pout))
                chk(0, "R3 sio_out moved while sclk high", sio_out, s_pout);
            if (sclk && !s_psclk && ce) begin
                s_rises++;
                if (s_last_rise >= 0)
                    chk(cyc - s_last_rise == 2 * HD, "R6 sclk period", cyc - s_last_rise, 2 * HD);
                s_last_rise = cyc;
                if (!s_cmd_ok || !s_rd) begin
                    s_sh[s_bits] = sio_out;
                    s_bits++;
                end else begin
                    chk(sio_oe == 1'b0, "R5 line released in read data", sio_oe, 0);
                end
                if (s_bits == 8) begin
                    s_bits = 0;
                    if (!s_cmd_ok) begin
                        s_cmd_ok = 1;
                        s_rd = s_sh[0];
                        s_addr = s_sh[6:1];
                        if (cmd_q.size() == 0) chk(0, "R2 unexpected command", s_sh, 0);
                        else begin
                            logic [7:0] e;
                            e = cmd_q.pop_front();
                            chk(s_sh == e, "R2 command byte", s_sh, e);
                        end
                    end else begin
                        if (wr_q.size() == 0) chk(0, "R4 unexpected write byte", s_sh, 0);
                        else begin
                            logic [7:0] e;
                            e = wr_q.pop_front();
                            chk(s_sh == e, "R4 write byte", s_sh, e);
                        end
                        slv_mem[6'(s_addr + s_idx)] = s_sh;
                        s_idx++;
                    end
                end
            end
            if (!sclk && s_psclk && ce && s_cmd_ok && s_rd) begin
                sio_in = slv_mem[6'(s_addr + s_rbyte)][s_rbit];
                s_rbit++;
                if (s_rbit == 8) begin s_rbit = 0; s_rbyte++; end
            end
            if (!ce && s_pce)
                chk(s_rises == 8 * (exp_len + 2), "R10 rising edge count", s_rises, 8 * (exp_len + 2));
        end
        s_psclk = sclk;
        s_pce = ce;
        s_pout = sio_out;
    end

    // Read-data monitor: pops expected bytes as rvalid pulses.
    always @(negedge clk) begin
        if (rst_n && rvalid) begin
            if (rd_q.size() == 0) chk(0, "R5 unexpected rvalid", rdata, 0);
            else begin
                logic [7:0] e;
                e = rd_q.pop_front();
                chk(rdata == e, "R5 read byte", rdata, e);
            end
        end
    end

    // Driver: queues expectations, issues the request, feeds write bytes.
    task automatic run_txn(input bit rd, input int a, input int ln, input bit poke);
        int nwr = 0, ndone = 0, k = 1, t = 0;
        bit pend = 0, poking = 0;
        while (busy) @(negedge clk);
        exp_len = ln;
        cmd_q.push_back({1'b1, 6'(a), rd});
        for (int i = 0; i <= ln; i++) begin
            if (rd) rd_q.push_back(ref_mem[6'(a + i)]);
            else begin
                wr_q.push_back(tx_buf[i]);
                ref_mem[6'(a + i)] = tx_buf[i];
            end
        end
        start = 1; rw = rd; addr = 6'(a); len = 4'(ln); wdata = tx_buf[0];
        @(negedge clk);
        start = 0;
        chk(busy == 1'b1, "R7 busy after start", busy, 1);
        while (busy) begin
            @(negedge clk);
            t++;
            if (poking) begin start = 0; poking = 0; end
            if (pend) begin wdata = tx_buf[k]; k++; pend = 0; end
            if (wready) begin nwr++; pend = 1; end
            if (done) ndone++;
            if (poke && t == 6 * HD) begin
                start = 1; rw = ~rd; addr = 6'(a ^ 5); len = 4'(ln ^ 3); poking = 1;
            end
        end
        start = 0;
        chk(nwr == (rd ? 0 : ln + 1), "R4 wready count", nwr, rd ? 0 : ln + 1);
        chk(ndone == 1, "R7 done pulse count", ndone, 1);
    endtask

    initial begin
        for (int i = 0; i < 64; i++) begin
            slv_mem[i] = 8'(i * 37 + 8'h5A);
            ref_mem[i] = 8'(i * 37 + 8'h5A);
        end
        repeat (5) @(negedge clk);
        chk({ce, sclk, sio_oe, sio_out, busy, done, rvalid, wready} == 8'h00,
            "R1 reset outputs", {ce, sclk, sio_oe, sio_out, busy, done, rvalid, wready}, 0);
        rst_n = 1;
        @(negedge clk);
        chk({ce, sclk, busy} == 3'b000, "R1 idle after reset", {ce, sclk, busy}, 0);

        tx_buf[0] = 8'hA5;
        run_txn(0, 3, 0, 0);                      // R4 single write
        run_txn(1, 3, 0, 0);                      // R5 single read back
        for (int i = 0; i < 16; i++) tx_buf[i] = 8'(8'h11 * i + 8'h03);
        run_txn(0, 0, 7, 0);                      // R2 cmd 0x80, R4 burst
        run_txn(1, 0, 7, 0);                      // R5 burst read back
        run_txn(1, 16, 15, 0);                    // R10 longest burst
        for (int i = 0; i < 16; i++) tx_buf[i] = 8'(8'hF0 - 8'h0D * i);
        run_txn(0, 40, 15, 0);                    // R4 longest write burst
        run_txn(1, 40, 2, 1);                     // R9 start while busy ignored
        tx_buf[0] = 8'h3C;
        run_txn(0, 63, 0, 0);                     // R2 top address, R8 back to back
        run_txn(1, 63, 0, 0);                     // R2 cmd 0xFF

        repeat (4 * HD) @(negedge clk);
        chk(busy == 1'b0 && ce == 1'b0, "R9 no extra transaction", {busy, ce}, 0);
        chk(cmd_q.size() == 0, "R2 commands all seen", cmd_q.size(), 0);
        chk(wr_q.size() == 0, "R4 write bytes all seen", wr_q.size(), 0);
        chk(rd_q.size() == 0, "R5 read bytes all returned", rd_q.size(), 0);

        finished = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule